// File: doc/BRIEF.md
# Per-Bit Write Mask Generator

This block produces the per-bit write enable for a wide memory write path. At the start of each memory cycle it decides which data bits may be written, and it combines that decision with a select for each byte lane. The memory array sits outside the block and simply writes the bits whose enable is high.

Two masking modes coexist. In one-shot mode a masked cycle takes its mask straight from the data bus at the cycle-start strobe. In persistent mode a stored mask register, loaded once by a load-mask command, serves every masked cycle, and the bus value at cycle start is ignored. Persistent mode is sticky. Only a refresh command that carries the option-reset flag returns the block to one-shot mode. A plain refresh leaves both the mode and the stored mask as they were.

Top module: `bitwrite_mask_gen`

## Requirements
- R1: After reset the block is in one-shot mode and `wr_en` is all zeros until the first cycle start.
- R2: In one-shot mode, a cycle start with `cyc_we_n` low captures `data_in` as the cycle mask. From the next clock, `wr_en` equals that mask ANDed with the lane enables.
- R3: Mask polarity: a mask bit of 1 enables the write of that bit, and a mask bit of 0 blocks it.
- R4: A cycle start with `cyc_we_n` high applies no masking in either mode. The cycle mask becomes all ones.
- R5: A load-mask command stores `data_in` in the mask register and puts the block into persistent mode from the next clock.
- R6: In persistent mode, a cycle start with `cyc_we_n` low uses the stored mask. The value on `data_in` at that edge has no effect.
- R7: Persistent mode stays active across any number of cycles, loads and plain refreshes, until an option reset.
- R8: A refresh with `opt_reset` high returns the block to one-shot mode.
- R9: A refresh with `opt_reset` low changes neither the mode nor the stored mask.
- R10: `lane_sel[i]` gates bits `[i*LANE_W +: LANE_W]` of `wr_en` with no clock delay. Lane 0 is the low byte. A lane whose select is low is never enabled.
- R11: Commands that share a clock edge are ordered as follows. A cycle start uses the mode and stored mask from before that edge. An option reset overrides a load-mask at the same edge, and the load then has no effect.
- R12: Between cycle starts the cycle mask holds its value, whatever `data_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cyc_start | input | 1 | One-clock pulse marking the start of a memory cycle |
| cyc_we_n | input | 1 | Active-low write-enable level, sampled at cycle start |
| data_in | input | LANE_W*N_LANES | Data bus, used as the mask source |
| load_mask | input | 1 | Load the stored mask from `data_in` and enter persistent mode |
| refresh | input | 1 | Refresh command pulse |
| opt_reset | input | 1 | Option-reset flag, qualified by `refresh` |
| lane_sel | input | N_LANES | Byte-lane selects, bit 0 for the low lane |
| wr_en | output | LANE_W*N_LANES | Effective per-bit write enable |

## Verification
The bench builds the block with its defaults, `LANE_W` = 8 and `N_LANES` = 2, which gives a 16-bit enable split into two independently gated lanes. This width lets all four lane-select combinations and arbitrary 16-bit mask patterns be reached in a few hundred cycles. The random phase drives cycle starts, loads and refreshes together on the same edges, so the ordering rules between capture, load and option reset come up repeatedly. Those rules are also pinned down by directed cases.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_PERSIST = 1'b1
  } mask_mode_e;

endpackage

// File: rtl/bwm_rst_sync.sv
module bwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/bwm_mode_ctrl.sv
module bwm_mode_ctrl
  import bwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         refresh_i,
  input  logic         opt_rst_i,
  input  logic [W-1:0] data_i,
  output logic         persist_o,
  output logic [W-1:0] stored_o
);

  mask_mode_e   mode_q, mode_d;
  logic [W-1:0] stored_q, stored_d;
  logic         clr_req;
  logic         upd_en;

  // An option reset outranks a load arriving on the same edge.
  always_comb begin
    clr_req  = refresh_i && opt_rst_i;
    mode_d   = mode_q;
    stored_d = stored_q;
    if (clr_req) begin
      mode_d = MODE_ONESHOT;
    end else if (load_i) begin
      mode_d   = MODE_PERSIST;
      stored_d = data_i;
    end
    upd_en = clr_req || load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_ONESHOT;
      stored_q <= '1;
    end else if (upd_en) begin
      mode_q   <= mode_d;
      stored_q <= stored_d;
    end
  end

  assign persist_o = (mode_q == MODE_PERSIST);
  assign stored_o  = stored_q;

  a_r8_optreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_i && opt_rst_i) |=> !persist_o);

  a_r5_load_enters_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !(refresh_i && opt_rst_i)) |=> (persist_o && stored_o == $past(data_i)));

  a_r9_plain_refresh_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_i && !opt_rst_i && !load_i) |=> ($stable(persist_o) && $stable(stored_o)));

  a_r7_persist_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (persist_o && !(refresh_i && opt_rst_i)) |=> persist_o);

endmodule

// File: rtl/bwm_cycle_capture.sv
module bwm_cycle_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         we_n_i,
  input  logic         persist_i,
  input  logic [W-1:0] stored_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);

  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    if (we_n_i) begin
      mask_d = '1;
    end else if (persist_i) begin
      mask_d = stored_i;
    end else begin
      mask_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (start_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  a_r12_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(mask_o));

  a_r4_unmasked_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && we_n_i) |=> (mask_o == '1));

  a_r6_persist_uses_store: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !we_n_i && persist_i) |=> (mask_o == $past(stored_i)));

  a_r2_oneshot_uses_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !we_n_i && !persist_i) |=> (mask_o == $past(data_i)));

endmodule

// File: rtl/bwm_lane_gate.sv
module bwm_lane_gate #(
  parameter int LANE_W  = 8,
  parameter int N_LANES = 2
) (
  input  logic [LANE_W*N_LANES-1:0] mask_i,
  input  logic [N_LANES-1:0]        sel_i,
  output logic [LANE_W*N_LANES-1:0] wr_en_o
);

  for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
    assign wr_en_o[ln*LANE_W +: LANE_W] =
      mask_i[ln*LANE_W +: LANE_W] & {LANE_W{sel_i[ln]}};
  end

endmodule

// File: rtl/bitwrite_mask_gen.sv
module bitwrite_mask_gen #(
  parameter int LANE_W  = 8,
  parameter int N_LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cyc_start,
  input  logic                      cyc_we_n,
  input  logic [LANE_W*N_LANES-1:0] data_in,
  input  logic                      load_mask,
  input  logic                      refresh,
  input  logic                      opt_reset,
  input  logic [N_LANES-1:0]        lane_sel,
  output logic [LANE_W*N_LANES-1:0] wr_en
);

  localparam int W = LANE_W * N_LANES;

  logic         rst_n_s;
  logic         persist;
  logic [W-1:0] stored_mask;
  logic [W-1:0] cycle_mask;

  bwm_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  bwm_mode_ctrl #(.W(W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (load_mask),
    .refresh_i(refresh),
    .opt_rst_i(opt_reset),
    .data_i   (data_in),
    .persist_o(persist),
    .stored_o (stored_mask)
  );

  bwm_cycle_capture #(.W(W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (cyc_start),
    .we_n_i   (cyc_we_n),
    .persist_i(persist),
    .stored_i (stored_mask),
    .data_i   (data_in),
    .mask_o   (cycle_mask)
  );

  bwm_lane_gate #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_gate (
    .mask_i (cycle_mask),
    .sel_i  (lane_sel),
    .wr_en_o(wr_en)
  );

  for (genvar ln = 0; ln < N_LANES; ln++) begin : g_chk
    a_r10_lane_off: assert property (@(posedge clk) disable iff (!rst_n_s)
      !lane_sel[ln] |-> (wr_en[ln*LANE_W +: LANE_W] == '0));
  end

endmodule

// File: tb/sim_bitwrite_mask_gen.sv
module sim_bitwrite_mask_gen;

  localparam int LANE_W  = 8;
  localparam int N_LANES = 2;
  localparam int W       = LANE_W * N_LANES;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cyc_start, cyc_we_n, load_mask, refresh, opt_reset;
  logic [W-1:0]       data_in;
  logic [N_LANES-1:0] lane_sel;
  logic [W-1:0]       wr_en;

  int checks = 0;
  int fails  = 0;

  logic         m_persist;
  logic [W-1:0] m_stored;
  logic [W-1:0] m_cmask;

  always #2.5 clk = ~clk;

  bitwrite_mask_gen #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_we_n(cyc_we_n),
    .data_in(data_in), .load_mask(load_mask), .refresh(refresh),
    .opt_reset(opt_reset), .lane_sel(lane_sel), .wr_en(wr_en)
  );

  function automatic logic [W-1:0] lane_bits(input logic [N_LANES-1:0] s);
    logic [W-1:0] r;
    for (int i = 0; i < N_LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{s[i]}};
    return r;
  endfunction

  function automatic logic [W-1:0] expect_en();
    return m_cmask & lane_bits(lane_sel);
  endfunction

  task automatic chk(input logic [W-1:0] exp, input string tag);
    checks++;
    if (wr_en !== exp) begin
      fails++;
      $display("FAIL %s: wr_en=%h expected=%h", tag, wr_en, exp);
    end
  endtask

  // Drive one clock of stimulus (called at a negedge), advance the model,
  // then clear the pulses at the next negedge.
  task automatic cyc(input logic cs, input logic wen, input logic [W-1:0] d,
                     input logic ld, input logic rf, input logic orst);
    cyc_start = cs; cyc_we_n = wen; data_in = d;
    load_mask = ld; refresh = rf; opt_reset = orst;
    if (cs) m_cmask = wen ? '1 : (m_persist ? m_stored : d);
    if (rf && orst) m_persist = 1'b0;
    else if (ld) begin m_persist = 1'b1; m_stored = d; end
    @(negedge clk);
    cyc_start = 0; load_mask = 0; refresh = 0; opt_reset = 0;
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 0; cyc_start = 0; cyc_we_n = 1; data_in = '0;
    load_mask = 0; refresh = 0; opt_reset = 0; lane_sel = '1;
    m_persist = 0; m_stored = '1; m_cmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk('0, "R1 reset output");

    cyc(1, 0, 16'hA5C3, 0, 0, 0); chk(16'hA5C3, "R2 one-shot capture");
    cyc(1, 0, 16'h0000, 0, 0, 0); chk(16'h0000, "R3 zero mask blocks");
    cyc(1, 0, 16'hFFFF, 0, 0, 0); chk(16'hFFFF, "R3 one mask allows");
    cyc(1, 1, 16'h0000, 0, 0, 0); chk(16'hFFFF, "R4 unmasked cycle");

    cyc(1, 0, 16'h5AF0, 0, 0, 0);
    lane_sel = 2'b01; #1; chk(16'h00F0, "R10 low lane only");
    lane_sel = 2'b10; #1; chk(16'h5A00, "R10 high lane only");
    lane_sel = 2'b00; #1; chk(16'h0000, "R10 no lanes");
    lane_sel = 2'b11; @(negedge clk);

    cyc(0, 0, 16'h1111, 0, 0, 0);
    cyc(0, 1, 16'h2222, 0, 0, 0); chk(16'h5AF0, "R12 mask holds");

    cyc(0, 1, 16'h0F0F, 1, 0, 0);
    cyc(1, 0, 16'hFFFF, 0, 0, 0); chk(16'h0F0F, "R5 load enters persistent");
    cyc(1, 0, 16'h0000, 0, 0, 0); chk(16'h0F0F, "R6 bus ignored");
    cyc(0, 1, 16'h0000, 0, 1, 0);
    cyc(1, 0, 16'h1234, 0, 0, 0); chk(16'h0F0F, "R9 plain refresh keeps");
    repeat (5) cyc(0, 1, 16'hDEAD, 0, 0, 0);
    cyc(1, 0, 16'h4321, 0, 0, 0); chk(16'h0F0F, "R7 persistent sticky");
    cyc(1, 1, 16'h0000, 0, 0, 0); chk(16'hFFFF, "R4 unmasked in persistent");

    cyc(1, 0, 16'h3C3C, 1, 0, 0); chk(16'h0F0F, "R11 capture before load");
    cyc(1, 0, 16'h0000, 0, 0, 0); chk(16'h3C3C, "R11 load took effect");
    cyc(0, 1, 16'hFF00, 1, 1, 1);
    cyc(1, 0, 16'h1111, 0, 0, 0); chk(16'h1111, "R11 option reset wins");

    cyc(0, 1, 16'h00F0, 1, 0, 0);
    cyc(0, 1, 16'h0000, 0, 1, 1);
    cyc(1, 0, 16'hABCD, 0, 0, 0); chk(16'hABCD, "R8 option reset to one-shot");

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] d;
      logic cs, wen, ld, rf, orst;
      d    = W'($urandom);
      cs   = ($urandom % 2) == 0;
      wen  = ($urandom % 4) == 0;
      ld   = ($urandom % 8) == 0;
      rf   = ($urandom % 6) == 0;
      orst = ($urandom % 2) == 0;
      lane_sel = N_LANES'($urandom);
      cyc(cs, wen, d, ld, rf, orst);
      chk(expect_en(), "R2/R6/R10 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule